// File: doc/BRIEF.md
# Wake and Keep-Alive Power Controller

This block is the on/off state machine of a multi-rail supply device. A wake input, already compared against its voltage threshold, is debounced; once it is recognised the block enables the pre-regulator and core rail, waits for the pre-regulator to report in range before it enables the two I/O rails, and releases a reset output once every rail has been in range for a fixed time.

The device then stays on for as long as at least one of three conditions holds: the wake input is high, software has set a power-hold bit, or software keeps refreshing a keep-alive bit before each keep-alive window runs out. Any change of level on the wake input also opens a fresh window. When none of the three holds, the block powers down. It drops the I/O rails and the reset at once, and it keeps the core and pre-regulator rails for a fixed delay before it returns to off. A recognised wake during power-down starts the power-up again. A switched battery output follows the on states, gated by a watchdog-served flag. All delays are parameters counted in clock cycles, and regulators appear as digital in-range flags.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: A wake is recognised when `wake_i` is sampled high on FILT_LEN+1 consecutive clock edges; a low sample restarts the count. From off (state code 0) a high sample enters the wake-filter state (code 1), and a low sample there returns to off.
- R2: `prereg_en_o` and `core_en_o` are high in power-up (code 2), keep-alive-on (code 3), held-on (code 4) and power-down (code 5), and low in codes 0 and 1.
- R3: `io5_en_o` and `io_en_o` are high only in codes 2 to 4 and only after `prereg_ok_i` has been sampled high on IO_DLY consecutive edges, counted from the edge after power-up is entered. A low sample clears them on the next cycle.
- R4: `rst_out_o` goes high in codes 2 to 4 once the I/O rails are enabled and all four in-range flags have been sampled high on RST_DLY consecutive edges. Any flag sampled low drops it on the next cycle.
- R5: Power-up moves to an on state at the first edge where the reset output is high: code 4 if the wake input or the hold bit is high, otherwise code 3.
- R6: A `hold_wr_i` strobe loads `hold_val_i` into the hold bit. While it is set, the device stays in code 4 whatever the keep-alive window does.
- R7: The keep-alive window is loaded with KA_LEN when a wake is recognised, and in codes 2 to 4 on each change of the wake level and each `ka_wr_i` strobe; otherwise it counts down to zero. With the wake input and the hold bit low, the device remains in code 3 while the window is open.
- R8: In an on state with the wake input low, the hold bit clear and the window closed, the device enters power-down (code 5). The I/O enables and the reset drop at once, and the core and pre-regulator enables stay high for CORE_DLY cycles before off.
- R9: A wake recognised during power-down returns the device to power-up (code 2).
- R10: `vbsw_en_o` is high exactly when the state is code 3 or 4 and `wdog_ok_i` is high.
- R11: After reset the state is off and every enable and the reset output are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wake_i | input | 1 | Wake input is above its threshold |
| hold_wr_i | input | 1 | Write strobe for the power-hold bit |
| hold_val_i | input | 1 | Value written to the power-hold bit |
| ka_wr_i | input | 1 | Keep-alive refresh strobe |
| prereg_ok_i | input | 1 | Pre-regulator in range |
| io5_ok_i | input | 1 | 5 V I/O rail in range |
| io_ok_i | input | 1 | Selectable I/O rail in range |
| core_ok_i | input | 1 | Core rail in range |
| wdog_ok_i | input | 1 | Watchdog is being served correctly |
| prereg_en_o | output | 1 | Pre-regulator enable |
| core_en_o | output | 1 | Core rail enable |
| io5_en_o | output | 1 | 5 V I/O rail enable |
| io_en_o | output | 1 | Selectable I/O rail enable |
| rst_out_o | output | 1 | Reset output, high when released |
| vbsw_en_o | output | 1 | Switched battery output enable |
| state_o | output | 3 | Current state code |

## Verification
The assertions take for granted that the in-range flags and the wake, hold and keep-alive inputs are synchronous to the clock and stable at each rising edge. They also take for granted that every delay parameter is at least one, because the reset and I/O checks look one cycle back at the in-range inputs. The stimulus changes inputs only at falling edges. It moves the rail flags independently of the enables, including drops of the pre-regulator and core flags while on. Every power-down delay is longer than the wake filter, so that a wake during power-down can be tried.

// File: rtl/pwr_wake_pkg.sv
package pwr_wake_pkg;
  typedef enum logic [2:0] {
    PW_OFF  = 3'd0,
    PW_FILT = 3'd1,
    PW_RAMP = 3'd2,
    PW_KEEP = 3'd3,
    PW_HELD = 3'd4,
    PW_DOWN = 3'd5
  } pw_state_e;
endpackage

// File: rtl/pwr_wake_filter.sv
module pwr_wake_filter #(
  parameter int unsigned FILT_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wake_i,
  output logic evt_o
);
  localparam int unsigned CW = $clog2(FILT_LEN + 2);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!wake_i)                         cnt_d = '0;
    else if (cnt_q == CW'(FILT_LEN + 1)) cnt_d = cnt_q;
    else                                 cnt_d = cnt_q + 1'b1;
  end

  assign evt_o = wake_i && (cnt_q == CW'(FILT_LEN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R1: recognition needs the input high on the previous edge as well
  assert_evt_after_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |-> $past(wake_i));
endmodule

// File: rtl/pwr_ka_window.sv
module pwr_ka_window #(
  parameter int unsigned KA_LEN = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic live_o
);
  localparam int unsigned KW = $clog2(KA_LEN + 1);

  logic [KW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (load_i)             cnt_d = KW'(KA_LEN);
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    else                    cnt_d = cnt_q;
  end

  assign live_o = load_i || (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R7: a reload keeps the window open on the following cycle
  assert_window_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> live_o);
endmodule

// File: rtl/pwr_rst_timer.sv
module pwr_rst_timer #(
  parameter int unsigned RST_DLY = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ok_i,
  input  logic gate_i,
  output logic rel_o
);
  localparam int unsigned RW = $clog2(RST_DLY + 1);

  logic [RW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!ok_i)                       cnt_d = '0;
    else if (cnt_q == RW'(RST_DLY))  cnt_d = cnt_q;
    else                             cnt_d = cnt_q + 1'b1;
  end

  assign rel_o = gate_i && (cnt_q == RW'(RST_DLY));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4: release only follows a cycle in which every rail was good
  assert_release_needs_ok_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rel_o |-> $past(ok_i));
endmodule

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl
  import pwr_wake_pkg::*;
#(
  parameter int unsigned FILT_LEN = 16,
  parameter int unsigned KA_LEN   = 1000,
  parameter int unsigned IO_DLY   = 200,
  parameter int unsigned CORE_DLY = 200,
  parameter int unsigned RST_DLY  = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wake_i,
  input  logic       hold_wr_i,
  input  logic       hold_val_i,
  input  logic       ka_wr_i,
  input  logic       prereg_ok_i,
  input  logic       io5_ok_i,
  input  logic       io_ok_i,
  input  logic       core_ok_i,
  input  logic       wdog_ok_i,
  output logic       prereg_en_o,
  output logic       core_en_o,
  output logic       io5_en_o,
  output logic       io_en_o,
  output logic       rst_out_o,
  output logic       vbsw_en_o,
  output logic [2:0] state_o
);
  localparam int unsigned DMAX = (IO_DLY > CORE_DLY) ? IO_DLY : CORE_DLY;
  localparam int unsigned DW   = $clog2(DMAX + 1);

  logic [1:0]    sync_q;
  logic          rst_i;
  pw_state_e     st_q, st_d;
  logic [DW-1:0] dly_q, dly_d;
  logic          hold_q, wake_q;
  logic          wake_evt, ka_load, ka_live, rst_rel;
  logic          on_st, run_st, io_on, all_ok, awake_req;

  // reset: asserted asynchronously, released on the second clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_i = sync_q[1];

  pwr_wake_filter #(.FILT_LEN(FILT_LEN)) u_filt (
    .clk(clk), .rst_n(rst_i), .wake_i(wake_i), .evt_o(wake_evt)
  );

  pwr_ka_window #(.KA_LEN(KA_LEN)) u_ka (
    .clk(clk), .rst_n(rst_i), .load_i(ka_load), .live_o(ka_live)
  );

  pwr_rst_timer #(.RST_DLY(RST_DLY)) u_rst (
    .clk(clk), .rst_n(rst_i), .ok_i(all_ok), .gate_i(on_st), .rel_o(rst_rel)
  );

  assign on_st     = (st_q == PW_RAMP) || (st_q == PW_KEEP) || (st_q == PW_HELD);
  assign run_st    = (st_q == PW_KEEP) || (st_q == PW_HELD);
  assign io_on     = on_st && (dly_q == DW'(IO_DLY));
  assign all_ok    = io_on && prereg_ok_i && io5_ok_i && io_ok_i && core_ok_i;
  assign ka_load   = wake_evt || (on_st && ((wake_i != wake_q) || ka_wr_i));
  assign awake_req = wake_i || hold_q;

  // next state
  always_comb begin
    st_d = st_q;
    case (st_q)
      PW_OFF:  if (wake_i) st_d = PW_FILT;
      PW_FILT: begin
        if (wake_evt)     st_d = PW_RAMP;
        else if (!wake_i) st_d = PW_OFF;
      end
      PW_RAMP: if (rst_rel) st_d = awake_req ? PW_HELD : PW_KEEP;
      PW_KEEP, PW_HELD: begin
        if (awake_req)    st_d = PW_HELD;
        else if (ka_live) st_d = PW_KEEP;
        else              st_d = PW_DOWN;
      end
      PW_DOWN: begin
        if (wake_evt)                           st_d = PW_RAMP;
        else if (dly_q == DW'(CORE_DLY - 1))    st_d = PW_OFF;
      end
      default: st_d = PW_OFF;
    endcase
  end

  // sequencing delay counter: I/O ramp while on, core hold-off while down
  always_comb begin
    dly_d = '0;
    if (st_d == PW_DOWN) begin
      if (st_q == PW_DOWN) dly_d = dly_q + 1'b1;
    end else if ((st_d == PW_RAMP || st_d == PW_KEEP || st_d == PW_HELD) && on_st) begin
      if (prereg_ok_i) dly_d = (dly_q == DW'(IO_DLY)) ? dly_q : dly_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      st_q   <= PW_OFF;
      dly_q  <= '0;
      wake_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      dly_q  <= dly_d;
      wake_q <= wake_i;
      if (hold_wr_i) hold_q <= hold_val_i;
    end
  end

  assign prereg_en_o = on_st || (st_q == PW_DOWN);
  assign core_en_o   = on_st || (st_q == PW_DOWN);
  assign io5_en_o    = io_on;
  assign io_en_o     = io_on;
  assign rst_out_o   = rst_rel;
  assign vbsw_en_o   = run_st && wdog_ok_i;
  assign state_o     = st_q;

  // R3: I/O rails never enabled without the pre-regulator good one edge before
  assert_io_after_prereg_R3: assert property (@(posedge clk) disable iff (!rst_i)
    io_en_o |-> $past(prereg_ok_i));

  // R4: reset released only after all four rails were reported good
  assert_rst_after_rails_R4: assert property (@(posedge clk) disable iff (!rst_i)
    rst_out_o |-> $past(prereg_ok_i && io5_ok_i && io_ok_i && core_ok_i));

  // R8: power-down is entered only from an on state
  assert_down_from_on_R8: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(st_q == PW_DOWN) |-> $past(st_q == PW_KEEP || st_q == PW_HELD));

  // R8: the core rail is switched off only at the end of power-down
  assert_core_off_late_R8: assert property (@(posedge clk) disable iff (!rst_i)
    $fell(core_en_o) |-> $past(st_q == PW_DOWN));

  // R9: a restart out of power-down needs the wake input high
  assert_restart_by_wake_R9: assert property (@(posedge clk) disable iff (!rst_i)
    ($past(st_q == PW_DOWN) && st_q == PW_RAMP) |-> $past(wake_i));

  // R10: switched battery output only while the supply rails are up
  assert_vbsw_with_rails_R10: assert property (@(posedge clk) disable iff (!rst_i)
    vbsw_en_o |-> (core_en_o && prereg_en_o));
endmodule

// File: tb/pwr_wake_ctrl_bench.sv
module pwr_wake_ctrl_bench;
  localparam int CLK_P = 10;
  localparam int F  = 3;
  localparam int KA = 30;
  localparam int IO = 10;
  localparam int CD = 10;
  localparam int RD = 12;

  logic clk = 1'b0;
  logic rst_n;
  logic wake, hwr, hval, kwr, pok, v5ok, vok, cok, wdg;
  logic prereg_en, core_en, io5_en, io_en, rst_out, vbsw_en;
  logic [2:0] st_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit armed = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  pwr_wake_ctrl #(.FILT_LEN(F), .KA_LEN(KA), .IO_DLY(IO), .CORE_DLY(CD), .RST_DLY(RD))
    u_pwr_wake_ctrl (
      .clk(clk), .rst_n(rst_n), .wake_i(wake), .hold_wr_i(hwr), .hold_val_i(hval),
      .ka_wr_i(kwr), .prereg_ok_i(pok), .io5_ok_i(v5ok), .io_ok_i(vok), .core_ok_i(cok),
      .wdog_ok_i(wdg), .prereg_en_o(prereg_en), .core_en_o(core_en), .io5_en_o(io5_en),
      .io_en_o(io_en), .rst_out_o(rst_out), .vbsw_en_o(vbsw_en), .state_o(st_o));

  // behavioural reference model
  int m_st, m_f, m_ka, m_hold, m_wq, m_d, m_ok, m_sync;

  function automatic bit m_on();
    return (m_st == 2) || (m_st == 3) || (m_st == 4);
  endfunction
  function automatic bit m_io();
    return m_on() && (m_d == IO);
  endfunction
  function automatic bit m_rel();
    return m_on() && (m_ok == RD);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_f = 0; m_ka = 0; m_hold = 0; m_wq = 0; m_d = 0; m_ok = 0; m_sync = 0;
    end else if (m_sync < 2) begin
      m_sync = m_sync + 1;
    end else begin
      bit evt, load, live, allok, req;
      int nst, nd;
      evt   = wake && (m_f == F);
      load  = evt || (m_on() && ((int'(wake) != m_wq) || kwr));
      live  = (m_ka != 0) || load;
      allok = m_io() && pok && v5ok && vok && cok;
      req   = wake || (m_hold != 0);
      nst = m_st;
      case (m_st)
        0: if (wake) nst = 1;
        1: nst = evt ? 2 : (wake ? 1 : 0);
        2: if (m_rel()) nst = req ? 4 : 3;
        3, 4: nst = req ? 4 : (live ? 3 : 5);
        5: nst = evt ? 2 : ((m_d == CD - 1) ? 0 : 5);
        default: nst = 0;
      endcase
      nd = 0;
      if (nst == 5) nd = (m_st == 5) ? m_d + 1 : 0;
      else if (nst >= 2 && nst <= 4 && m_on() && pok) nd = (m_d == IO) ? m_d : m_d + 1;
      m_f    = !wake ? 0 : ((m_f == F + 1) ? m_f : m_f + 1);
      m_ka   = load ? KA : ((m_ka != 0) ? m_ka - 1 : 0);
      if (hwr) m_hold = hval;
      m_wq   = wake;
      m_ok   = allok ? ((m_ok == RD) ? RD : m_ok + 1) : 0;
      m_d    = nd;
      m_st   = nst;
    end
  end

  task automatic cmp(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  // compare every cycle, a quarter period after the rising edge
  always @(posedge clk) begin
    if (armed) begin
      #(CLK_P/4);
      cmp("R5 state", int'(st_o), m_st);
      cmp("R2 prereg_en", int'(prereg_en), int'(m_on() || m_st == 5));
      cmp("R2 core_en", int'(core_en), int'(m_on() || m_st == 5));
      cmp("R3 io5_en", int'(io5_en), int'(m_io()));
      cmp("R3 io_en", int'(io_en), int'(m_io()));
      cmp("R4 rst_out", int'(rst_out), int'(m_rel()));
      cmp("R10 vbsw_en", int'(vbsw_en), int'((m_st == 3 || m_st == 4) && wdg));
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_st(int exp, int maxc, string req);
    bit hit = 1'b0;
    for (int k = 0; k < maxc && !hit; k++) begin
      @(negedge clk);
      if (int'(st_o) == exp) hit = 1'b1;
    end
    cmp(req, int'(st_o), exp);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog (R1..R11 run): actual=hung expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    wake = 0; hwr = 0; hval = 0; kwr = 0;
    pok = 1; v5ok = 1; vok = 1; cok = 1; wdg = 1;
    armed = 1'b1;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
    // R11: reset state
    cmp("R11 state", int'(st_o), 0);
    cmp("R11 enables", int'({prereg_en, core_en, io5_en, io_en, rst_out, vbsw_en}), 0);

    // R1: a glitch of F high samples is rejected
    wake = 1; cyc(F);
    wake = 0; cyc(2);
    cmp("R1 glitch rejected", int'(st_o), 0);

    // R1, R2, R3, R4, R5: clean power-up held by the wake input
    wake = 1;
    wait_st(2, 10, "R1 wake recognised");
    cmp("R2 prereg on in power-up", int'(prereg_en), 1);
    wait_st(4, 60, "R5 held-on reached");
    cmp("R4 reset released", int'(rst_out), 1);
    cmp("R3 io rails on", int'(io_en), 1);

    // R4: a core rail dropout pulls the reset
    cok = 0; cyc(1);
    cmp("R4 reset on dropout", int'(rst_out), 0);
    cok = 1; cyc(RD + 2);
    cmp("R4 reset re-released", int'(rst_out), 1);

    // R10: watchdog gating of the switched battery output
    wdg = 0; cyc(1);
    cmp("R10 vbsw off", int'(vbsw_en), 0);
    wdg = 1; cyc(1);
    cmp("R10 vbsw on", int'(vbsw_en), 1);

    // R3: pre-regulator dropout removes the I/O rails
    pok = 0; cyc(2);
    cmp("R3 io off", int'(io_en), 0);
    pok = 1; cyc(IO + 2);
    cmp("R3 io back", int'(io_en), 1);
    cyc(RD + 2);

    // R7: refreshes keep the device on past several windows
    wake = 0; cyc(2);
    cmp("R7 keep-alive state", int'(st_o), 3);
    for (int i = 0; i < 3; i++) begin
      cyc(20); kwr = 1; cyc(1); kwr = 0;
    end
    cmp("R7 still on after refreshes", int'(st_o), 3);

    // R8: window expiry powers down with the core delayed
    wait_st(5, 40, "R8 power-down entered");
    cmp("R8 io dropped", int'(io_en), 0);
    cmp("R8 core kept", int'(core_en), 1);
    wait_st(0, 20, "R8 off after delay");

    // R6: the hold bit keeps the device on
    wake = 1;
    wait_st(4, 80, "R5 held-on again");
    hwr = 1; hval = 1; cyc(1); hwr = 0;
    wake = 0; cyc(60);
    cmp("R6 held by hold bit", int'(st_o), 4);
    hwr = 1; hval = 0; cyc(1); hwr = 0;
    cyc(1);
    cmp("R8 down after hold cleared", int'(st_o), 5);

    // R9: wake during power-down restarts power-up
    wake = 1;
    wait_st(2, 8, "R9 restart");
    wait_st(4, 80, "R5 held-on after restart");
    wake = 0;
    wait_st(0, 80, "R8 final off");
    cyc(2);
    finish_run();
  end
endmodule